// File: doc/BRIEF.md
# PoE Port Power Sequencer

This block sequences power delivery for a four-port power-sourcing controller. Each port carries its own copy of the same state machine. The machine moves the port through signature detection, classification, a timed power-up and a powered state, and it removes power when a fault or a load removal is seen. The analog side is not part of the block. Detection validity, the class code, current-limit activity, the output-good condition and load removal all arrive as per-port digital flags.

A 2-bit field sets the mode of each port:

- **Auto:** the port runs every step without help.
- **Semi-auto:** the port detects and classifies, then waits for a software power-on strobe before it applies power.
- **Manual:** single-shot push strobes start each phase, and a power-on strobe starts power-up.
- **Off:** all activity stops and the port is unpowered.

Two shared 2-bit fields set the startup window and the overcurrent tolerance window. The block reports the result of each phase as 3-bit status codes. Shutoffs are reported as one-cycle event pulses.

Top module: `poe_port_seq`

## Requirements
- R1: Each port has its own 2-bit mode field: 00 off, 01 manual, 10 semi-auto, 11 auto. Ports run independently, so one port's inputs and results never change another port's outputs.
- R2: In auto mode with detection enabled and a valid signature, the port detects for DET_CYC cycles, then classifies for CLS_CYC cycles (when class is enabled), then raises its power enable with no strobe. pwr_en is seen high 1+DET_CYC+CLS_CYC clock edges after the mode is set. An invalid signature never powers the port.
- R3: det_stat reads 000 after reset, 001 after a valid detection and 010 after an invalid one. cls_stat holds the 3-bit class code sampled as the class phase ends. Both codes change only in the cycle a phase ends.
- R4: In semi-auto mode, a pwr_on strobe is honoured only while the port waits after a valid detection and classification. Power rises one edge after the strobe. A strobe at any other time is ignored, and after a shutoff the port waits again.
- R5: In manual mode, the det_en and cls_en levels are ignored. A det_push or cls_push strobe runs exactly one detection or classification phase. When both are strobed together, detection runs first and classification follows. cls_push alone classifies without detecting. A push while the port is off is discarded. A pwr_on strobe in idle starts power-up.
- R6: When the mode is off, pwr_en and pg are low one edge later and stay low, and no event pulse is produced.
- R7: During power-up, pwr_en stays high for exactly STARTUP_BASE<<start_sel cycles. At the end of that window, pg rises if pgood_in is high and ilim is low. Otherwise power drops and ev_sfail pulses for one cycle.
- R8: When powered, ilim held for FAULT_BASE<<fault_sel consecutive cycles removes power and pulses ev_maxi. A shorter burst leaves the port powered.
- R9: When powered, load_gone removes power one edge later and pulses ev_disc. If the overcurrent window expires in the same cycle, only ev_maxi pulses.
- R10: After any shutoff the port returns to idle. In auto mode it restarts detection at once, so power returns 1+DET_CYC+CLS_CYC edges after the drop when the load is still valid.
- R11: After reset every port is idle: no power, pg low, status codes zero and no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2*NPORTS | Per-port mode field |
| det_en | input | NPORTS | Detection enable level (auto/semi-auto) |
| cls_en | input | NPORTS | Classification enable level (auto/semi-auto) |
| det_push | input | NPORTS | One-cycle detection strobe (manual) |
| cls_push | input | NPORTS | One-cycle classification strobe (manual) |
| pwr_on | input | NPORTS | One-cycle power-on strobe |
| start_sel | input | 2 | Startup window select |
| fault_sel | input | 2 | Overcurrent window select |
| det_ok | input | NPORTS | Signature valid flag |
| cls_code | input | 3*NPORTS | Measured class per port |
| ilim | input | NPORTS | Current limit active |
| pgood_in | input | NPORTS | Output condition good |
| load_gone | input | NPORTS | Load removal seen |
| pwr_en | output | NPORTS | Port power switch enable |
| pg | output | NPORTS | Port powered and good |
| det_stat | output | 3*NPORTS | Detection result code |
| cls_stat | output | 3*NPORTS | Classification result code |
| ev_maxi | output | NPORTS | Overcurrent shutoff pulse |
| ev_disc | output | NPORTS | Load-removal shutoff pulse |
| ev_sfail | output | NPORTS | Startup failure pulse |

## Verification
The assertions assume that start_sel and fault_sel hold steady while any port is powering up or powered. If they did not, the window counters could pass a limit that shrank under them. They also assume that push and power-on strobes last a single cycle. The bench changes the select fields only while every affected port is off or waiting. It drives each strobe for exactly one clock and changes all inputs on the falling edge. Event timing is checked through a scoreboard of expected pulses, so any unexpected shutoff pulse is reported as well.

// File: rtl/poe_seq_pkg.sv
package poe_seq_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_MAN  = 2'b01,
    MODE_SEMI = 2'b10,
    MODE_AUTO = 2'b11
  } port_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DET, ST_CLS, ST_WAIT, ST_START, ST_ON
  } port_state_e;

  localparam logic [2:0] DSTAT_NONE = 3'b000;
  localparam logic [2:0] DSTAT_OK   = 3'b001;
  localparam logic [2:0] DSTAT_BAD  = 3'b010;

  // Window length: base count doubled per select step.
  function automatic int unsigned scaled_ticks(int unsigned base, logic [1:0] sel);
    return base << sel;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = en && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + W'(1);
  end

  // R7/R8: a running window never passes its programmed length
  assert_timer_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt < limit));

endmodule

// File: rtl/port_fsm.sv
module port_fsm
  import poe_seq_pkg::*;
#(
  parameter int TW           = 16,
  parameter int DET_CYC      = 6,
  parameter int CLS_CYC      = 3,
  parameter int STARTUP_BASE = 16,
  parameter int FAULT_BASE   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       det_en,
  input  logic       cls_en,
  input  logic       det_push,
  input  logic       cls_push,
  input  logic       pwr_on,
  input  logic [1:0] start_sel,
  input  logic [1:0] fault_sel,
  input  logic       det_ok,
  input  logic [2:0] cls_code,
  input  logic       ilim,
  input  logic       pgood_in,
  input  logic       load_gone,
  output logic       pwr_en,
  output logic       pg,
  output logic [2:0] det_stat,
  output logic [2:0] cls_stat,
  output logic       ev_maxi,
  output logic       ev_disc,
  output logic       ev_sfail
);
  port_state_e state, nxt;
  port_mode_e  md;
  logic det_pend, cls_pend, armed;
  logic det_go, cls_go, is_off, power_ok;
  logic phase_en, phase_clr, phase_done;
  logic fault_en, fault_done;
  logic det_end, cls_end, start_end;
  logic [TW-1:0] phase_lim, fault_lim;

  assign md       = port_mode_e'(mode);
  assign is_off   = (md == MODE_OFF);
  assign det_go   = det_push | det_pend;
  assign cls_go   = cls_push | cls_pend;
  assign power_ok = pgood_in & ~ilim;

  // Where a port goes once it has a valid signature and class
  function automatic port_state_e after_ready(port_mode_e m);
    case (m)
      MODE_AUTO: return ST_START;
      MODE_SEMI: return ST_WAIT;
      default:   return ST_IDLE;
    endcase
  endfunction

  always_comb begin
    case (state)
      ST_DET:   phase_lim = TW'(DET_CYC);
      ST_CLS:   phase_lim = TW'(CLS_CYC);
      ST_START: phase_lim = TW'(scaled_ticks(STARTUP_BASE, start_sel));
      default:  phase_lim = '1;
    endcase
  end
  assign fault_lim = TW'(scaled_ticks(FAULT_BASE, fault_sel));

  assign phase_en  = state inside {ST_DET, ST_CLS, ST_START};
  assign phase_clr = (nxt != state);
  assign fault_en  = (state == ST_ON) & ilim;

  seq_timer #(.W(TW)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(phase_clr), .en(phase_en),
    .limit(phase_lim), .done(phase_done));

  seq_timer #(.W(TW)) u_fault (
    .clk(clk), .rst_n(rst_n), .clr(~fault_en), .en(fault_en),
    .limit(fault_lim), .done(fault_done));

  assign det_end   = (state == ST_DET)   & phase_done & ~is_off;
  assign cls_end   = (state == ST_CLS)   & phase_done & ~is_off;
  assign start_end = (state == ST_START) & phase_done & ~is_off;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:
        if (md == MODE_MAN)
          nxt = det_go ? ST_DET : cls_go ? ST_CLS : pwr_on ? ST_START : ST_IDLE;
        else if (!is_off)
          nxt = det_en ? ST_DET : cls_en ? ST_CLS : ST_IDLE;
      ST_DET:
        if (phase_done) begin
          if (md == MODE_MAN) nxt = cls_go ? ST_CLS : ST_IDLE;
          else if (!det_ok)   nxt = ST_IDLE;
          else if (cls_en)    nxt = ST_CLS;
          else                nxt = after_ready(md);
        end
      ST_CLS:
        if (phase_done) nxt = armed ? after_ready(md) : ST_IDLE;
      ST_WAIT:
        if (md != MODE_SEMI) nxt = ST_IDLE;
        else if (pwr_on)     nxt = ST_START;
      ST_START:
        if (phase_done) nxt = power_ok ? ST_ON : ST_IDLE;
      ST_ON:
        if (fault_done || load_gone) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    if (is_off) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      armed    <= 1'b0;
      det_pend <= 1'b0;
      cls_pend <= 1'b0;
      det_stat <= DSTAT_NONE;
      cls_stat <= 3'b000;
      ev_maxi  <= 1'b0;
      ev_disc  <= 1'b0;
      ev_sfail <= 1'b0;
    end else begin
      state    <= nxt;
      armed    <= (nxt == ST_IDLE) ? 1'b0 : (armed | (det_end & det_ok));
      det_pend <= (md == MODE_MAN) & det_go & ~(nxt == ST_DET && state != ST_DET);
      cls_pend <= (md == MODE_MAN) & cls_go & ~(nxt == ST_CLS && state != ST_CLS);
      if (det_end) det_stat <= det_ok ? DSTAT_OK : DSTAT_BAD;
      if (cls_end) cls_stat <= cls_code;
      ev_maxi  <= (state == ST_ON) & fault_done & ~is_off;
      ev_disc  <= (state == ST_ON) & load_gone & ~fault_done & ~is_off;
      ev_sfail <= start_end & ~power_ok;
    end
  end

  assign pwr_en = state inside {ST_START, ST_ON};
  assign pg     = (state == ST_ON);

  assert_off_mode_unpowered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_off |=> (!pwr_en && !pg && !ev_maxi && !ev_disc && !ev_sfail));

  assert_semi_needs_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_en) && $past(md) == MODE_SEMI) |-> $past(pwr_on));

  assert_pg_needs_good_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg) |-> ($past(pgood_in) && !$past(ilim)));

  assert_maxi_after_overcurrent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_maxi |-> ($past(ilim) && !pwr_en));

  assert_disc_after_removal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_disc |-> ($past(load_gone) && !pwr_en && !ev_maxi));

endmodule

// File: rtl/poe_port_seq.sv
module poe_port_seq #(
  parameter int NPORTS       = 4,
  parameter int TW           = 16,
  parameter int DET_CYC      = 6,
  parameter int CLS_CYC      = 3,
  parameter int STARTUP_BASE = 16,
  parameter int FAULT_BASE   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*NPORTS-1:0]   mode,
  input  logic [NPORTS-1:0]     det_en,
  input  logic [NPORTS-1:0]     cls_en,
  input  logic [NPORTS-1:0]     det_push,
  input  logic [NPORTS-1:0]     cls_push,
  input  logic [NPORTS-1:0]     pwr_on,
  input  logic [1:0]            start_sel,
  input  logic [1:0]            fault_sel,
  input  logic [NPORTS-1:0]     det_ok,
  input  logic [3*NPORTS-1:0]   cls_code,
  input  logic [NPORTS-1:0]     ilim,
  input  logic [NPORTS-1:0]     pgood_in,
  input  logic [NPORTS-1:0]     load_gone,
  output logic [NPORTS-1:0]     pwr_en,
  output logic [NPORTS-1:0]     pg,
  output logic [3*NPORTS-1:0]   det_stat,
  output logic [3*NPORTS-1:0]   cls_stat,
  output logic [NPORTS-1:0]     ev_maxi,
  output logic [NPORTS-1:0]     ev_disc,
  output logic [NPORTS-1:0]     ev_sfail
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    port_fsm #(
      .TW(TW), .DET_CYC(DET_CYC), .CLS_CYC(CLS_CYC),
      .STARTUP_BASE(STARTUP_BASE), .FAULT_BASE(FAULT_BASE)
    ) u_port (
      .clk(clk), .rst_n(rst_n),
      .mode(mode[2*p +: 2]),
      .det_en(det_en[p]), .cls_en(cls_en[p]),
      .det_push(det_push[p]), .cls_push(cls_push[p]), .pwr_on(pwr_on[p]),
      .start_sel(start_sel), .fault_sel(fault_sel),
      .det_ok(det_ok[p]), .cls_code(cls_code[3*p +: 3]),
      .ilim(ilim[p]), .pgood_in(pgood_in[p]), .load_gone(load_gone[p]),
      .pwr_en(pwr_en[p]), .pg(pg[p]),
      .det_stat(det_stat[3*p +: 3]), .cls_stat(cls_stat[3*p +: 3]),
      .ev_maxi(ev_maxi[p]), .ev_disc(ev_disc[p]), .ev_sfail(ev_sfail[p])
    );
  end
endmodule

// File: tb/test_poe_port_seq.sv
`timescale 1ns/1ps
module test_poe_port_seq;
  localparam int NP = 4, DETC = 6, CLSC = 3, SB = 16, FB = 8;
  localparam int K_MAXI = 0, K_DISC = 1, K_SFAIL = 2;
  localparam logic [1:0] M_OFF = 2'b00, M_MAN = 2'b01, M_SEMI = 2'b10, M_AUTO = 2'b11;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [2*NP-1:0] mode;
  logic [NP-1:0] det_en, cls_en, det_push, cls_push, pwr_on, det_ok, ilim, pgood_in, load_gone;
  logic [1:0] start_sel, fault_sel;
  logic [3*NP-1:0] cls_code;
  logic [NP-1:0] pwr_en, pg, ev_maxi, ev_disc, ev_sfail;
  logic [3*NP-1:0] det_stat, cls_stat;

  poe_port_seq #(.NPORTS(NP), .DET_CYC(DETC), .CLS_CYC(CLSC),
                 .STARTUP_BASE(SB), .FAULT_BASE(FB)) i_poe_port_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .det_en(det_en), .cls_en(cls_en),
    .det_push(det_push), .cls_push(cls_push), .pwr_on(pwr_on),
    .start_sel(start_sel), .fault_sel(fault_sel), .det_ok(det_ok),
    .cls_code(cls_code), .ilim(ilim), .pgood_in(pgood_in), .load_gone(load_gone),
    .pwr_en(pwr_en), .pg(pg), .det_stat(det_stat), .cls_stat(cls_stat),
    .ev_maxi(ev_maxi), .ev_disc(ev_disc), .ev_sfail(ev_sfail));

  int total = 0, bad = 0;
  bit finished = 0;
  int q_port[$], q_kind[$];
  string q_req[$];

  task automatic check_eq(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(int p, int k, string req);
    q_port.push_back(p); q_kind.push_back(k); q_req.push_back(req);
  endtask

  function automatic bit ev_bit(int p, int k);
    return (k == K_MAXI) ? ev_maxi[p] : (k == K_DISC) ? ev_disc[p] : ev_sfail[p];
  endfunction

  // Scoreboard monitor: each seen pulse is matched against the expected queue
  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < NP; p++) begin
        for (int k = 0; k < 3; k++) begin
          if (ev_bit(p, k)) begin
            if (q_kind.size() == 0) begin
              total++; bad++;
              $display("FAIL R6 unexpected event: actual=port%0d/kind%0d expected=none", p, k);
            end else begin
              string r; int ep, ek;
              ep = q_port.pop_front(); ek = q_kind.pop_front(); r = q_req.pop_front();
              check_eq(r, "event port", p, ep);
              check_eq(r, "event kind", k, ek);
            end
          end
        end
      end
    end
  end

  function automatic bit sig(int p, int which);
    return (which == 0) ? pwr_en[p] : pg[p];
  endfunction

  task automatic wait_for(int p, int which, bit val, int lim, output int n);
    n = 0;
    while (sig(p, which) != val && n < lim) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    rst_n = 0; mode = '0; det_en = '0; cls_en = '0; det_push = '0; cls_push = '0;
    pwr_on = '0; det_ok = '0; ilim = '0; pgood_in = '0; load_gone = '0;
    start_sel = 2'd0; fault_sel = 2'd0; cls_code = '0;
    tick(3);
    rst_n = 1;
    tick(1);
    // R11 reset state
    check_eq("R11", "pwr_en", int'(pwr_en), 0);
    check_eq("R11", "pg", int'(pg), 0);
    check_eq("R11", "det_stat", int'(det_stat), 0);
    check_eq("R11", "cls_stat", int'(cls_stat), 0);

    // R2 auto flow on port 0, R1 port 1 fails detection independently
    mode[1:0] = M_AUTO; det_en[0] = 1; cls_en[0] = 1; det_ok[0] = 1;
    cls_code[2:0] = 3'd3; pgood_in[0] = 1;
    mode[3:2] = M_AUTO; det_en[1] = 1; cls_en[1] = 1; det_ok[1] = 0;
    wait_for(0, 0, 1, 100, n);
    check_eq("R2", "edges to power", n, 1 + DETC + CLSC);
    check_eq("R3", "det_stat p0", int'(det_stat[2:0]), 1);
    check_eq("R3", "cls_stat p0", int'(cls_stat[2:0]), 3);
    check_eq("R1", "det_stat p1", int'(det_stat[5:3]), 2);
    check_eq("R1", "pwr_en p1..p3", int'(pwr_en[3:1]), 0);
    wait_for(0, 1, 1, 200, n);
    check_eq("R7", "startup edges to pg", n, SB);
    mode[3:2] = M_OFF;

    // R8 short overcurrent burst tolerated
    ilim[0] = 1; tick(FB - 1); ilim[0] = 0;
    tick(2);
    check_eq("R8", "pwr after short burst", int'(pwr_en[0]), 1);
    // R8 sustained overcurrent
    expect_ev(0, K_MAXI, "R8");
    ilim[0] = 1;
    wait_for(0, 0, 0, 200, n);
    ilim[0] = 0;
    check_eq("R8", "edges to overcurrent drop", n, FB);
    // R10 auto retry
    wait_for(0, 0, 1, 100, n);
    check_eq("R10", "edges to repower", n, 1 + DETC + CLSC);
    wait_for(0, 1, 1, 200, n);

    // R9 load removal
    expect_ev(0, K_DISC, "R9");
    load_gone[0] = 1; tick(1); load_gone[0] = 0;
    check_eq("R9", "pwr after removal", int'(pwr_en[0]), 0);
    wait_for(0, 0, 1, 100, n);
    check_eq("R10", "edges to repower after removal", n, 1 + DETC + CLSC);
    wait_for(0, 1, 1, 200, n);
    // R9 overcurrent wins over removal in same cycle
    expect_ev(0, K_MAXI, "R9");
    ilim[0] = 1; tick(FB - 1);
    load_gone[0] = 1; tick(1);
    load_gone[0] = 0; ilim[0] = 0;
    check_eq("R9", "pwr after joint fault", int'(pwr_en[0]), 0);
    // R6 shutdown during power-up
    wait_for(0, 0, 1, 100, n);
    mode[1:0] = M_OFF; tick(1);
    check_eq("R6", "pwr after off", int'(pwr_en[0]), 0);
    tick(30);
    check_eq("R6", "pwr stays off", int'(pwr_en[0]), 0);
    check_eq("R6", "pg stays off", int'(pg[0]), 0);

    // R3 invalid detection, status changes only at phase end
    det_ok[0] = 0; mode[1:0] = M_AUTO;
    tick(DETC);
    check_eq("R3", "det_stat before end", int'(det_stat[2:0]), 1);
    tick(1);
    check_eq("R3", "det_stat after end", int'(det_stat[2:0]), 2);
    tick(30);
    check_eq("R2", "no power on bad signature", int'(pwr_en[0]), 0);
    det_ok[0] = 1;
    wait_for(0, 0, 1, 100, n);
    check_eq("R10", "retry reaches power", int'(pwr_en[0]), 1);
    mode[1:0] = M_OFF; tick(2);

    // R4 semi-auto
    start_sel = 2'd2; pgood_in[0] = 0; cls_code[2:0] = 3'd6;
    mode[1:0] = M_SEMI; pwr_on[0] = 1; tick(1); pwr_on[0] = 0;
    tick(40);
    check_eq("R4", "no power before strobe", int'(pwr_en[0]), 0);
    check_eq("R3", "semi cls_stat", int'(cls_stat[2:0]), 6);
    expect_ev(0, K_SFAIL, "R7");
    pwr_on[0] = 1; tick(1); pwr_on[0] = 0;
    check_eq("R4", "power one edge after strobe", int'(pwr_en[0]), 1);
    wait_for(0, 0, 0, 300, n);
    check_eq("R7", "startup window sel=2", n, SB * 4);
    tick(40);
    check_eq("R4", "waits again after drop", int'(pwr_en[0]), 0);
    mode[1:0] = M_OFF; start_sel = 2'd0; pgood_in[0] = 1; tick(2);

    // R5 manual pushbuttons
    det_ok[0] = 0; cls_code[2:0] = 3'd5;
    det_push[0] = 1; tick(1); det_push[0] = 0;
    mode[1:0] = M_MAN;
    tick(20);
    check_eq("R5", "levels and off-mode push ignored", int'(det_stat[2:0]), 1);
    det_push[0] = 1; tick(1); det_push[0] = 0; tick(DETC);
    check_eq("R5", "one detection", int'(det_stat[2:0]), 2);
    det_ok[0] = 1; tick(20);
    check_eq("R5", "single shot", int'(det_stat[2:0]), 2);
    cls_push[0] = 1; tick(1); cls_push[0] = 0; tick(CLSC);
    check_eq("R5", "class only cls_stat", int'(cls_stat[2:0]), 5);
    check_eq("R5", "class only det_stat", int'(det_stat[2:0]), 2);
    cls_code[2:0] = 3'd2;
    det_push[0] = 1; cls_push[0] = 1; tick(1); det_push[0] = 0; cls_push[0] = 0;
    tick(DETC);
    check_eq("R5", "detect first det_stat", int'(det_stat[2:0]), 1);
    check_eq("R5", "class pending", int'(cls_stat[2:0]), 5);
    tick(CLSC);
    check_eq("R5", "class after detect", int'(cls_stat[2:0]), 2);
    check_eq("R5", "no auto power", int'(pwr_en[0]), 0);
    pwr_on[0] = 1; tick(1); pwr_on[0] = 0;
    check_eq("R5", "manual power-on", int'(pwr_en[0]), 1);
    wait_for(0, 1, 1, 200, n);
    check_eq("R7", "manual startup edges", n, SB);
    mode[1:0] = M_OFF;
    tick(5);
    check_eq("R9", "scoreboard drained", q_kind.size(), 0);
    finish_run();
  end
endmodule